// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is one channel of an event timer. A free-running tick counter, owned by the surrounding timer unit, is fed in every cycle; the channel holds a programmable comparator and raises a single-cycle event when the counter reaches it. The channel can run as a one-shot or as a periodic source. It can also be narrowed to half the counter width (32 bits with the default 64-bit counter). In periodic mode the comparator reloads itself by a stored period and skips forward past any periods that were missed.

Software reaches the channel through three write strobes: one for the configuration word, one for the low comparator half and one for the high half. The comparator and the configuration word are returned for readback. Routing the event to an interrupt line, the counter itself and address decode belong to the enclosing unit.

Top module: `evt_tmr_chan`

## Requirements
- R1: After reset the configuration reads 0x30, the comparator reads all ones, the period is zero and no event is pending or produced.
- R2: Configuration bits are: bit 0 channel enable, bit 1 periodic, bit 2 narrow (half-width) mode, bit 3 direct-set. Bits 0 to 3 take the written value. Bit 4 (periodic capable) and bit 5 (full width capable) always read 1. Bits 7:6 always read 0.
- R3: In one-shot mode an armed channel pulses `fire_o` for one cycle, in the cycle after the clock edge where the counter equals the comparator, and then disarms.
- R4: The channel arms in three cases: a configuration write sets bit 0 while it was 0 and the global enable is high; a comparator write occurs while bit 0 and the global enable are both high; the global enable rises while bit 0 is set and the comparator is not all ones. If the comparator is at or behind the counter when armed, the event fires two cycles after the arming edge.
- R5: A configuration write with bit 0 clear, or a low global enable, disarms the channel, and no event appears in the following cycle or later.
- R6: With bit 1 clear, a comparator write loads that half of the comparator. With bit 1 set, a write loads the period. It also loads the comparator only if bit 3 is set. Bit 3 clears after any comparator-half write.
- R7: A period written in periodic mode has its top bit forced to zero: bit 31 in narrow mode, bit 63 in full-width mode.
- R8: In periodic mode with a nonzero period, each event adds the period to the comparator. After a late event the comparator keeps advancing by the period until it is ahead of the counter, without further events, and the next event comes at that new value.
- R9: A configuration write with bit 2 set clears the upper halves of the comparator and period. While in narrow mode, high-half writes are ignored and comparison and reload use only the low halves, with a signed difference.
- R10: In narrow one-shot mode, if the counter's low half would wrap past all ones before reaching the comparator, an event fires when the low half is all ones, and a second event fires at the real match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Shared tick counter value |
| glb_en_i | input | 1 | Global timer enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cmp_lo_wr_i | input | 1 | Low comparator half write strobe |
| cmp_hi_wr_i | input | 1 | High comparator half write strobe |
| cmp_wdata_i | input | CNT_W/2 | Comparator half write data |
| fire_o | output | 1 | Single-cycle event pulse |
| cmp_o | output | CNT_W | Comparator readback |
| cfg_o | output | 8 | Configuration readback |

## Verification
On every cycle, the assertions check three register rules and two disarm rules. The register rules are the top-bit masking of a written period, the zero upper halves in narrow mode, and the self-clearing of the direct-set bit. The disarm rules are the silence after a disarming write and while the global enable is low. Exact event positions can only be shown by the bench's scenarios: the match cycle, the immediate event on a stale comparator, the series of periodic events, the catch-up after a counter jump, and the extra wrap event in narrow one-shot mode. Each of these needs a counter trajectory that the bench constructs.

// File: rtl/evt_tmr_pkg.sv
// Shared definitions for the event timer channel: configuration bit
// positions, the writable mask and the reset image of the config word.
package evt_tmr_pkg;
    localparam int CFG_W     = 8;
    localparam int CB_EN     = 0;   // channel enable
    localparam int CB_PER    = 1;   // periodic mode
    localparam int CB_NAR    = 2;   // narrow (half-width) mode
    localparam int CB_SET    = 3;   // direct-set of comparator in periodic mode
    localparam int CB_CAPP   = 4;   // periodic capable, read-only 1
    localparam int CB_CAPW   = 5;   // full-width capable, read-only 1
    localparam logic [CFG_W-1:0] CFG_WMASK = 8'h0F;
    localparam logic [CFG_W-1:0] CFG_RST   = 8'h30;
endpackage

// File: rtl/evt_cfg_reg.sv
// Channel configuration register.
// Holds the writable mode bits, forces the capability bits and self-clears the
// direct-set bit after a comparator write. Assumes a config write and a
// comparator write never arrive in the same cycle; the config write wins.
module evt_cfg_reg
    import evt_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             setval_clr_i,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_q;

    // Config storage: masked write, otherwise clear direct-set on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (wr_i) begin
            cfg_q <= (wdata_i & CFG_WMASK) | (CFG_RST & ~CFG_WMASK);
        end else if (setval_clr_i) begin
            cfg_q[CB_SET] <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/evt_cmp_reg.sv
// Comparator and period storage.
// Routes comparator-half writes to the comparator or the period according to
// the mode, masks the period top bit, truncates on entering narrow mode and
// applies periodic reloads requested by the scheduler. Writes win over reloads.
module evt_cmp_reg #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lo_wr_i,
    input  logic               hi_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    input  logic               periodic_i,
    input  logic               narrow_i,
    input  logic               setval_i,
    input  logic               narrow_set_i,
    input  logic               reload_i,
    output logic [CNT_W-1:0]   cmp_o,
    output logic [CNT_W-1:0]   period_o
);
    localparam int H = CNT_W / 2;

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic             to_cmp;
    logic [H-1:0]     wd_nomsb;
    logic [H-1:0]     sum_n;
    logic [CNT_W-1:0] sum_w;

    // Decide whether a write targets the comparator and precompute sums.
    always_comb begin
        to_cmp   = !periodic_i || setval_i;
        wd_nomsb = {1'b0, wdata_i[H-2:0]};
        sum_n    = cmp_q[H-1:0] + per_q[H-1:0];
        sum_w    = cmp_q + per_q;
    end

    // Comparator and period update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
            per_q <= '0;
        end else if (narrow_set_i) begin
            cmp_q <= {{H{1'b0}}, cmp_q[H-1:0]};
            per_q <= {{H{1'b0}}, per_q[H-1:0]};
        end else if (lo_wr_i) begin
            if (to_cmp) begin
                cmp_q[H-1:0] <= wdata_i;
            end
            if (periodic_i) begin
                per_q[H-1:0] <= narrow_i ? wd_nomsb : wdata_i;
            end
        end else if (hi_wr_i) begin
            if (!narrow_i) begin
                if (to_cmp) begin
                    cmp_q[CNT_W-1:H] <= wdata_i;
                end else begin
                    per_q[CNT_W-1:H] <= wd_nomsb;
                end
            end
        end else if (reload_i) begin
            cmp_q <= narrow_i ? {{H{1'b0}}, sum_n} : sum_w;
        end
    end

    assign cmp_o    = cmp_q;
    assign period_o = per_q;

    // R7
    per_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && periodic_i && narrow_i && !narrow_set_i) |=> !per_q[H-1]);

    // R7
    per_msb_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr_i && periodic_i && !setval_i && !narrow_i && !narrow_set_i && !lo_wr_i)
        |=> !per_q[CNT_W-1]);

    // R9
    narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_i |-> (cmp_q[CNT_W-1:H] == '0) && (per_q[CNT_W-1:H] == '0));
endmodule

// File: rtl/evt_sched.sv
// Arming and event scheduler.
// Compares the counter with the comparator in full or narrow width using a
// signed difference, produces the fire pulse, asks for periodic reloads and
// catches up after missed periods one add per cycle. Assumes the counter
// advances by less than the period per cycle during catch-up.
module evt_sched #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             periodic_i,
    input  logic             narrow_i,
    input  logic             glb_en_i,
    input  logic             arm_req_i,
    input  logic             disarm_req_i,
    output logic             fire_o,
    output logic             reload_o
);
    localparam int H = CNT_W / 2;

    logic             armed_q, arm_pend_q, catch_q, wrap_q, fire_q;
    logic [CNT_W-1:0] diff_w;
    logic [H-1:0]     diff_n, dist_n, wrap_left;
    logic             due_w, due_n, due, at_wrap, hit, per_live, live, wrap_sel;

    // Distance to target in both widths and the derived event conditions.
    always_comb begin
        diff_w    = cmp_i - count_i;
        diff_n    = cmp_i[H-1:0] - count_i[H-1:0];
        due_w     = diff_w[CNT_W-1] || (diff_w == '0);
        due_n     = diff_n[H-1] || (diff_n == '0);
        due       = narrow_i ? due_n : due_w;
        at_wrap   = &count_i[H-1:0];
        live      = glb_en_i && !disarm_req_i && !arm_req_i;
        hit       = armed_q && !catch_q && (wrap_q ? at_wrap : due);
        per_live  = periodic_i && (narrow_i ? (|period_i[H-1:0]) : (|period_i));
        dist_n    = due_n ? {{(H-1){1'b0}}, 1'b1} : diff_n;
        wrap_left = ~count_i[H-1:0];
        wrap_sel  = narrow_i && !periodic_i && (wrap_left < dist_n);
        reload_o  = live && ((hit && !wrap_q && per_live) || (catch_q && due));
    end

    // Channel state: disarm, deferred arm, fire and catch-up sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            arm_pend_q <= 1'b0;
            catch_q    <= 1'b0;
            wrap_q     <= 1'b0;
            fire_q     <= 1'b0;
        end else if (!glb_en_i || disarm_req_i) begin
            armed_q    <= 1'b0;
            arm_pend_q <= 1'b0;
            catch_q    <= 1'b0;
            wrap_q     <= 1'b0;
            fire_q     <= 1'b0;
        end else if (arm_req_i) begin
            armed_q    <= 1'b0;
            arm_pend_q <= 1'b1;
            catch_q    <= 1'b0;
            wrap_q     <= 1'b0;
            fire_q     <= 1'b0;
        end else if (arm_pend_q) begin
            arm_pend_q <= 1'b0;
            armed_q    <= 1'b1;
            wrap_q     <= wrap_sel;
            fire_q     <= 1'b0;
        end else begin
            fire_q <= hit;
            if (hit) begin
                if (wrap_q) begin
                    wrap_q <= 1'b0;
                end else if (per_live) begin
                    catch_q <= 1'b1;
                end else begin
                    armed_q <= 1'b0;
                end
            end else if (catch_q && !due) begin
                catch_q <= 1'b0;
            end
        end
    end

    assign fire_o = fire_q;

    // R4
    arm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req_i |=> !fire_o);
endmodule

// File: rtl/evt_tmr_chan.sv
// Event timer channel top.
// Decodes write strobes into arm and disarm requests, tracks the global enable
// edge and ties together the config register, comparator storage and
// scheduler. Assumes at most one of the three write strobes per cycle.
module evt_tmr_chan
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               glb_en_i,
    input  logic               cfg_wr_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic               cmp_lo_wr_i,
    input  logic               cmp_hi_wr_i,
    input  logic [CNT_W/2-1:0] cmp_wdata_i,
    output logic               fire_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic [CFG_W-1:0]   cfg_o
);
    logic [CFG_W-1:0] cfg;
    logic [CNT_W-1:0] cmp, period;
    logic             glb_q, glb_rise, cmp_wr, arm_req, disarm_req;
    logic             narrow_set, reload;

    // Global enable history for the rising-edge arm case.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= 1'b0;
        end else begin
            glb_q <= glb_en_i;
        end
    end

    // Arm/disarm decode from the write strobes and the global enable edge.
    always_comb begin
        glb_rise   = glb_en_i && !glb_q;
        cmp_wr     = cmp_lo_wr_i || cmp_hi_wr_i;
        narrow_set = cfg_wr_i && cfg_wdata_i[CB_NAR];
        disarm_req = cfg_wr_i && !cfg_wdata_i[CB_EN];
        arm_req    = glb_en_i && (
                       (cfg_wr_i && cfg_wdata_i[CB_EN] && !cfg[CB_EN]) ||
                       (!cfg_wr_i && cmp_wr && cfg[CB_EN]) ||
                       (!cfg_wr_i && glb_rise && cfg[CB_EN] && (cmp != '1)));
    end

    evt_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (cfg_wr_i),
        .wdata_i      (cfg_wdata_i),
        .setval_clr_i (cmp_wr),
        .cfg_o        (cfg)
    );

    evt_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_wr_i      (cmp_lo_wr_i),
        .hi_wr_i      (cmp_hi_wr_i),
        .wdata_i      (cmp_wdata_i),
        .periodic_i   (cfg[CB_PER]),
        .narrow_i     (cfg[CB_NAR]),
        .setval_i     (cfg[CB_SET]),
        .narrow_set_i (narrow_set),
        .reload_i     (reload),
        .cmp_o        (cmp),
        .period_o     (period)
    );

    evt_sched #(.CNT_W(CNT_W)) u_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_i      (count_i),
        .cmp_i        (cmp),
        .period_i     (period),
        .periodic_i   (cfg[CB_PER]),
        .narrow_i     (cfg[CB_NAR]),
        .glb_en_i     (glb_en_i),
        .arm_req_i    (arm_req),
        .disarm_req_i (disarm_req),
        .fire_o       (fire_o),
        .reload_o     (reload)
    );

    assign cmp_o = cmp;
    assign cfg_o = cfg;

    // R5
    disarm_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !cfg_wdata_i[CB_EN]) |=> !fire_o);

    // R5
    glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> !fire_o);

    // R6
    setval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !cfg_wr_i) |=> !cfg_o[CB_SET]);
endmodule

// File: tb/evt_tmr_chan_tb.sv
`timescale 1ns/1ps
module evt_tmr_chan_tb;
    localparam logic [7:0] EN = 8'h01, PER = 8'h02, NAR = 8'h04, SET = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        glb_en_i = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        cmp_lo_wr_i = 1'b0;
    logic        cmp_hi_wr_i = 1'b0;
    logic [31:0] cmp_wdata_i = '0;
    logic        fire_o;
    logic [63:0] cmp_o;
    logic [7:0]  cfg_o;

    int          nchk = 0, nerr = 0, nfires = 0;
    logic [63:0] last_fire = '0;
    bit          run = 1'b0;

    evt_tmr_chan u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .glb_en_i(glb_en_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .cmp_lo_wr_i(cmp_lo_wr_i), .cmp_hi_wr_i(cmp_hi_wr_i),
        .cmp_wdata_i(cmp_wdata_i), .fire_o(fire_o), .cmp_o(cmp_o), .cfg_o(cfg_o)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_cfg(input logic [7:0] w);
        return (w & 8'h0F) | 8'h30;
    endfunction

    // Next event after a late periodic event, from the catch-up rule (R8).
    function automatic logic [63:0] exp_catch(input logic [63:0] t, input logic [63:0] p,
                                               input logic [63:0] f);
        logic [63:0] k = 64'd1;
        while (t + p * k <= f + k) k = k + 64'd1;
        return t + p * k;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (fire_o) begin
            nfires++;
            last_fire = count_i;
        end
        if (run) count_i = count_i + 64'd1;
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        cfg_wdata_i = d; cfg_wr_i = 1'b1; tick(); cfg_wr_i = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] d);
        cmp_wdata_i = d; cmp_lo_wr_i = 1'b1; tick(); cmp_lo_wr_i = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] d);
        cmp_wdata_i = d; cmp_hi_wr_i = 1'b1; tick(); cmp_hi_wr_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wait_fire(input int maxc, output logic [63:0] at);
        int n0 = nfires;
        int k = 0;
        at = '1;
        while (nfires == n0 && k < maxc) begin
            tick();
            k++;
        end
        if (nfires != n0) at = last_fire;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [63:0] tgt, nt, c0, f1, at;
        logic [7:0]  m_cfg;
        logic [63:0] m_cmp;
        int          n0;
        void'($urandom(32'd4242));

        idle(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cfg", {56'd0, cfg_o}, 64'h30);
        chk("R1 cmp", cmp_o, '1);
        chk("R1 fire", {63'd0, fire_o}, 64'd0);

        // R3 one-shot full width
        count_i = 64'd100; run = 1'b1; glb_en_i = 1'b1;
        wr_lo(32'd200); wr_hi(32'd0);
        chk("R6 one-shot write loads cmp", cmp_o, 64'd200);
        n0 = nfires;
        wr_cfg(EN);
        while (count_i < 64'd260) tick();
        chk("R3 single event", nfires - n0, 64'd1);
        chk("R3 event at match", last_fire, 64'd200);

        // R4 stale comparator fires two cycles after arming edge
        wr_cfg(8'h00);
        wr_lo(32'd50);
        n0 = nfires; c0 = count_i;
        wr_cfg(EN);
        idle(10);
        chk("R4 immediate event count", nfires - n0, 64'd1);
        chk("R4 immediate event time", last_fire, c0 + 64'd2);

        // R6/R8 periodic with direct-set
        wr_cfg(8'h00);
        wr_cfg(PER | SET);
        tgt = count_i + 64'd40;
        wr_lo(tgt[31:0]);
        wr_lo(32'd40);
        wr_hi(32'd0);
        chk("R6 period write leaves cmp", cmp_o, tgt);
        chk("R6 direct-set cleared", {63'd0, cfg_o[3]}, 64'd0);
        wr_cfg(EN | PER);
        for (int i = 0; i < 4; i++) begin
            wait_fire(100, at);
            chk("R8 periodic event", at, tgt + 64'd40 * i);
        end

        // R8 catch-up after counter jump
        nt = tgt + 64'd160;
        while (count_i != nt - 64'd5) tick();
        count_i = count_i + 64'd100;
        wait_fire(20, f1);
        chk("R8 late event", f1, nt + 64'd95);
        wait_fire(100, at);
        chk("R8 event after catch-up", at, exp_catch(nt, 64'd40, f1));

        // R5 disarm by write
        wr_cfg(PER);
        n0 = nfires;
        idle(150);
        chk("R5 no event after disarm", nfires - n0, 64'd0);

        // R5 global enable low, then R4 re-arm on rise
        wr_cfg(8'h00);
        wr_lo(count_i[31:0] + 32'd30);
        wr_cfg(EN);
        idle(5);
        glb_en_i = 1'b0;
        n0 = nfires;
        idle(60);
        chk("R5 no event while global off", nfires - n0, 64'd0);
        glb_en_i = 1'b1; c0 = count_i;
        idle(10);
        chk("R4 global rise event count", nfires - n0, 64'd1);
        chk("R4 global rise event time", last_fire, c0 + 64'd2);

        // R9/R7 narrow periodic
        wr_cfg(8'h00);
        count_i = 64'h5_0000_1000;
        wr_hi(32'hDEAD);
        chk("R6 hi write loads cmp", cmp_o[63:32], 64'hDEAD);
        wr_cfg(NAR);
        chk("R9 truncation", cmp_o[63:32], 64'd0);
        wr_cfg(NAR | PER | SET);
        wr_lo(32'h0000_1040);
        wr_lo(32'h8000_0010);
        wr_hi(32'h1234);
        chk("R9 hi write ignored", cmp_o, 64'h1040);
        wr_cfg(EN | PER | NAR);
        for (int i = 0; i < 3; i++) begin
            wait_fire(200, at);
            chk("R7 masked period event", at, 64'h5_0000_1040 + 64'h10 * i);
        end

        // R10 narrow one-shot wrap event
        wr_cfg(8'h00);
        count_i = 64'h2_FFFF_FFD0;
        wr_cfg(NAR);
        wr_lo(32'h10);
        wr_cfg(EN | NAR);
        wait_fire(100, at);
        chk("R10 wrap event", at, 64'h2_FFFF_FFFF);
        wait_fire(100, at);
        chk("R10 match after wrap", at, 64'h3_0000_0010);
        n0 = nfires;
        idle(60);
        chk("R10 no third event", nfires - n0, 64'd0);

        // R2/R6/R9 random register traffic with global enable off
        glb_en_i = 1'b0;
        wr_cfg(8'h00);
        m_cfg = 8'h30; m_cmp = 64'h10;
        for (int i = 0; i < 300; i++) begin
            int op = $urandom % 3;
            logic [31:0] d = $urandom;
            if (op == 0) begin
                m_cfg = exp_cfg(d[7:0]);
                if (d[2]) m_cmp[63:32] = '0;
                wr_cfg(d[7:0]);
            end else if (op == 1) begin
                if (!m_cfg[1] || m_cfg[3]) m_cmp[31:0] = d;
                m_cfg[3] = 1'b0;
                wr_lo(d);
            end else begin
                if (!m_cfg[2] && (!m_cfg[1] || m_cfg[3])) m_cmp[63:32] = d;
                m_cfg[3] = 1'b0;
                wr_hi(d);
            end
            chk("R2 cfg readback", {56'd0, cfg_o}, {56'd0, m_cfg});
            chk("R6 cmp readback", cmp_o, m_cmp);
            chk("R5 no event", {63'd0, fire_o}, 64'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule